// File: doc/BRIEF.md
# Skip-Based Sparse Coordinate Intersector

This block finds the coordinates that two sparse fibers have in common. Each fiber is held as a short list of coordinates in strictly increasing order. Software or an upstream engine loads the list into one of two scanner buffers through a write port, and sets the list's length in a length register. A start pulse then begins a run. During the run the intersect stage emits, in increasing order, every coordinate that occurs in both lists. Each beat carries the coordinate and its position in each list, so that downstream logic can fetch the matching values.

A plain merge steps one coordinate per cycle. Here, whenever the two head coordinates differ, each scanner takes the other's head as a skip bound. Every coordinate below that bound can never match. Both scanners then jump in one cycle to their first entry at or above the bound, and the discarded entries are never shown to the intersect stage. The scanner that is ahead receives a bound no larger than its own head, so it stays where it is. The scanner that is behind moves forward by one entry or more.

The result stream is valid/ready. A beat is transferred on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the beat holds still and both scanners stall. `out_valid` is driven without looking at `out_ready`. Once either list runs out, the run ends and `done` rises. `done` stays high until the next start.

Top module: `coord_intersect`

## Requirements
- R1: While reset is held and after it is released, `done` and `out_valid` are low until a run finishes.
- R2: A run emits each coordinate present in both loaded lists exactly once, in strictly increasing order, and nothing else.
- R3: Each beat's `out_idx_a` and `out_idx_b` are the zero-based positions of `out_coord` in list A and list B.
- R4: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with `out_coord`, `out_idx_a` and `out_idx_b` unchanged.
- R5: `done` rises only after the last beat has been accepted. While `done` is high, `out_valid` is low. `done` stays high until the next start.
- R6: If either effective length is zero, the run emits no beat and `done` is high within two cycles after the start edge.
- R7: For lists A = {1,5,6,7,8} and B = {2,3,4,5,9} with `out_ready` held high, the only beat is coordinate 5 (A index 1, B index 3). The beat is valid two cycles after the start edge, and `done` is high five cycles after it. This is below the nine cycles a one-per-cycle merge needs.
- R8: With `out_ready` held high, each cycle of a run consumes at least one list entry, so `done` is high no later than lenA + lenB + 1 cycles after the start edge.
- R9: `wr_list` = 0 selects list A and 1 selects list B for both the entry write (`wr_en`) and the length write (`len_en`). A written length above DEPTH acts as DEPTH. List contents and lengths persist across runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_list | input | 1 | List select for writes: 0 = A, 1 = B |
| wr_en | input | 1 | Write `wr_coord` to entry `wr_addr` of the selected list |
| wr_addr | input | IW | Entry index |
| wr_coord | input | CW | Coordinate value |
| len_en | input | 1 | Write `len_val` to the selected list's length |
| len_val | input | LW | List length, 0 to DEPTH (larger values clamp) |
| start | input | 1 | Begins a run when no run is active |
| done | output | 1 | Run finished; held until next start |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer accepts the beat |
| out_coord | output | CW | Matching coordinate |
| out_idx_a | output | IW | Position of the coordinate in list A |
| out_idx_b | output | IW | Position of the coordinate in list B |

## Verification
Counting from the rising edge that samples `start`, the block spends one cycle for each skip and one cycle for each accepted beat. After a list is exhausted, `done` follows one cycle later. A beat whose heads already match is therefore valid in the cycle right after the start edge. The bench pulses `start` between edges and counts edges from there. It samples outputs and drives `out_ready` only at falling edges, so each check sees the cycle where a beat or `done` is due. For the worked example it checks the exact cycle of the beat and of `done`. For every run with `out_ready` held high, it checks the R8 bound on the cycle count.

// File: rtl/isect_pkg.sv
package isect_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/isect_scan.sv
// One scanner: coordinate store, length register, head pointer and a
// single-cycle skip finder that compares every live entry with the bound.
module isect_scan #(
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [CW-1:0] wr_coord,
  input  logic          len_en,
  input  logic [LW-1:0] len_val,
  input  logic          restart,
  input  logic          step,
  input  logic          jump,
  input  logic [CW-1:0] jump_tgt,
  output logic [CW-1:0] head,
  output logic [IW-1:0] head_idx,
  output logic          exh
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic [CW-1:0] store [DEPTH];
  logic [LW-1:0] len_q;
  logic [LW-1:0] eff_len;
  logic [LW-1:0] pos;
  logic [LW-1:0] pos_nx;
  logic [DEPTH-1:0] hit;
  logic          found;
  logic [LW-1:0] first;

  assign eff_len  = (len_q > DEPTH_L) ? DEPTH_L : len_q;
  assign head_idx = pos[IW-1:0];
  assign head     = store[pos[IW-1:0]];
  assign pos_nx   = pos + LW'(1);

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_coord;
  end

  // Candidate entries: at or after the head, inside the list, not below the bound.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cand
    localparam logic [LW-1:0] GI = LW'(g);
    assign hit[g] = (GI >= pos) && (GI < eff_len) && (store[g] >= jump_tgt);
  end

  always_comb begin
    found = 1'b0;
    first = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        first = LW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      pos   <= '0;
      exh   <= 1'b1;
    end else begin
      if (len_en) len_q <= len_val;
      if (restart) begin
        pos <= '0;
        exh <= (eff_len == '0);
      end else if (step) begin
        pos <= pos_nx;
        exh <= (pos_nx >= eff_len);
      end else if (jump) begin
        if (found) pos <= first;
        else       exh <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/isect_ctrl.sv
// Run control: compares the two heads, emits on equality, skips otherwise.
module isect_ctrl
  import isect_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] head_a,
  input  logic [CW-1:0] head_b,
  input  logic          exh_a,
  input  logic          exh_b,
  input  logic          out_ready,
  output logic          restart,
  output logic          step,
  output logic          jump,
  output logic          out_valid,
  output logic          done
);
  phase_t phase;
  logic   live;

  assign live      = (phase == PH_RUN) && !exh_a && !exh_b;
  assign restart   = start && (phase != PH_RUN);
  assign out_valid = live && (head_a == head_b);
  assign step      = out_valid && out_ready;
  assign jump      = live && (head_a != head_b);
  assign done      = (phase == PH_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE, PH_DONE: if (start) phase <= PH_RUN;
        PH_RUN:           if (exh_a || exh_b) phase <= PH_DONE;
        default:          phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coord_intersect.sv
module coord_intersect #(
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int IW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_list,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [CW-1:0] wr_coord,
  input  logic          len_en,
  input  logic [LW-1:0] len_val,
  input  logic          start,
  output logic          done,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_coord,
  output logic [IW-1:0] out_idx_a,
  output logic [IW-1:0] out_idx_b
);
  localparam int NSCAN = 2;

  logic [CW-1:0] head     [NSCAN];
  logic [IW-1:0] head_idx [NSCAN];
  logic [NSCAN-1:0] exh;
  logic restart, step, jump;

  for (genvar g = 0; g < NSCAN; g++) begin : g_scan
    isect_scan #(.DEPTH(DEPTH), .CW(CW), .IW(IW), .LW(LW)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_list == 1'(g))),
      .wr_addr  (wr_addr),
      .wr_coord (wr_coord),
      .len_en   (len_en && (wr_list == 1'(g))),
      .len_val  (len_val),
      .restart  (restart),
      .step     (step),
      .jump     (jump),
      .jump_tgt (head[NSCAN-1-g]),
      .head     (head[g]),
      .head_idx (head_idx[g]),
      .exh      (exh[g])
    );
  end

  isect_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .head_a    (head[0]),
    .head_b    (head[1]),
    .exh_a     (exh[0]),
    .exh_b     (exh[1]),
    .out_ready (out_ready),
    .restart   (restart),
    .step      (step),
    .jump      (jump),
    .out_valid (out_valid),
    .done      (done)
  );

  assign out_coord = head[0];
  assign out_idx_a = head_idx[0];
  assign out_idx_b = head_idx[1];
endmodule

// File: rtl/coord_intersect_chk.sv
module coord_intersect_chk #(
  parameter int CW = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] out_coord,
  input logic [IW-1:0] out_idx_a,
  input logic [IW-1:0] out_idx_b
);
  logic          run_q;
  logic          have_prev;
  logic [CW-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      have_prev <= 1'b0;
      prev      <= '0;
    end else begin
      if (start && !run_q) begin
        run_q     <= 1'b1;
        have_prev <= 1'b0;
      end else begin
        if (done) run_q <= 1'b0;
        if (out_valid && out_ready) begin
          have_prev <= 1'b1;
          prev      <= out_coord;
        end
      end
    end
  end

  assert_increasing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && have_prev) |-> (out_coord > prev));

  assert_hold_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coord)
                                   && $stable(out_idx_a) && $stable(out_idx_b)));

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!done && !out_valid));
endmodule

bind coord_intersect coord_intersect_chk #(.CW(CW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_coord (out_coord),
  .out_idx_a (out_idx_a),
  .out_idx_b (out_idx_b)
);

// File: tb/coord_intersect_bench.sv
module coord_intersect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CW = 16;
  localparam int IW = 4;
  localparam int LW = 5;
  localparam int RUN_LIMIT = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_list = 1'b0, wr_en = 1'b0, len_en = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [IW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_coord = '0;
  logic [LW-1:0] len_val = '0;
  logic done, out_valid;
  logic [CW-1:0] out_coord;
  logic [IW-1:0] out_idx_a, out_idx_b;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  int la [DEPTH];
  int lb [DEPTH];
  int na, nb;
  int exp_c [DEPTH];
  int exp_ia [DEPTH];
  int exp_ib [DEPTH];
  int ne;
  int k_done, k_first;

  coord_intersect #(.DEPTH(DEPTH), .CW(CW)) u_coord_intersect (
    .clk(clk), .rst_n(rst_n), .wr_list(wr_list), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_coord(wr_coord), .len_en(len_en), .len_val(len_val), .start(start),
    .done(done), .out_valid(out_valid), .out_ready(out_ready), .out_coord(out_coord),
    .out_idx_a(out_idx_a), .out_idx_b(out_idx_b)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Write list sel (0 = A, 1 = B) with the given length register value.
  task automatic load(input int sel, input int lenv);
    int n = (lenv > DEPTH) ? DEPTH : lenv;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_list = sel[0]; wr_en = 1'b1; wr_addr = IW'(i);
      wr_coord = CW'(sel == 0 ? la[i] : lb[i]);
    end
    @(negedge clk);
    wr_en = 1'b0; wr_list = sel[0]; len_en = 1'b1; len_val = LW'(lenv);
    @(negedge clk);
    len_en = 1'b0;
    if (sel == 0) na = n; else nb = n;
  endtask

  task automatic expect_calc();
    ne = 0;
    for (int i = 0; i < na; i++)
      for (int j = 0; j < nb; j++)
        if (la[i] == lb[j]) begin
          exp_c[ne] = la[i]; exp_ia[ne] = i; exp_ib[ne] = j; ne++;
        end
  endtask

  task automatic run(input bit rand_ready, input string tag);
    int got = 0;
    int k = 0;
    bit hold = 0;
    int hc = 0, hia = 0, hib = 0;
    expect_calc();
    k_first = -1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (k < RUN_LIMIT) begin
      if (done) break;
      if (hold) begin
        check(out_valid && int'(out_coord) == hc && int'(out_idx_a) == hia
              && int'(out_idx_b) == hib, "R4 hold", int'(out_coord), hc);
      end
      out_ready = rand_ready ? ($urandom % 3 != 0) : 1'b1;
      hold = 0;
      if (out_valid) begin
        if (k_first < 0) k_first = k;
        if (out_ready) begin
          if (got < ne) begin
            check(int'(out_coord) == exp_c[got], {tag, " R2 coord"}, int'(out_coord), exp_c[got]);
            check(int'(out_idx_a) == exp_ia[got], {tag, " R3 idx_a"}, int'(out_idx_a), exp_ia[got]);
            check(int'(out_idx_b) == exp_ib[got], {tag, " R3 idx_b"}, int'(out_idx_b), exp_ib[got]);
          end
          got++;
        end else begin
          hold = 1; hc = int'(out_coord); hia = int'(out_idx_a); hib = int'(out_idx_b);
        end
      end
      @(negedge clk);
      k++;
    end
    k_done = k;
    check(done, {tag, " R5 done reached"}, k, RUN_LIMIT);
    check(got == ne, {tag, " R2 beat count"}, got, ne);
    check(!out_valid, {tag, " R5 no beat when done"}, int'(out_valid), 0);
    if (!rand_ready)
      check(k <= na + nb + 1, {tag, " R8 cycle bound"}, k, na + nb + 1);
    out_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!done && !out_valid, "R1 in reset", int'(done) + int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !out_valid, "R1 after reset", int'(done) + int'(out_valid), 0);

    // R7: worked example
    la[0] = 1; la[1] = 5; la[2] = 6; la[3] = 7; la[4] = 8;
    lb[0] = 2; lb[1] = 3; lb[2] = 4; lb[3] = 5; lb[4] = 9;
    load(0, 5); load(1, 5);
    run(1'b0, "example");
    check(k_first == 2, "R7 beat cycle", k_first, 2);
    check(k_done == 5, "R7 done cycle", k_done, 5);
    repeat (3) @(negedge clk);
    check(done && !out_valid, "R5 done held", int'(done), 1);

    // R9: persistence, rerun without reload
    run(1'b0, "rerun R9");
    check(k_done == 5, "R9 rerun done cycle", k_done, 5);

    // R6: empty A, then empty B
    load(0, 0);
    run(1'b0, "emptyA R6");
    check(k_done <= 2, "R6 empty A", k_done, 2);
    for (int i = 0; i < 5; i++) la[i] = i * 2;
    load(0, 5); load(1, 0);
    run(1'b0, "emptyB R6");
    check(k_done <= 2, "R6 empty B", k_done, 2);

    // Full identical lists; R9 clamp of length 20 to DEPTH on A
    for (int i = 0; i < DEPTH; i++) begin la[i] = 3 * i + 1; lb[i] = 3 * i + 1; end
    load(0, 20); load(1, DEPTH);
    run(1'b0, "full R9 clamp");
    check(ne == DEPTH, "R9 clamp match count", ne, DEPTH);

    // Disjoint interleaved lists
    for (int i = 0; i < DEPTH; i++) begin la[i] = 2 * i; lb[i] = 2 * i + 1; end
    load(0, DEPTH); load(1, DEPTH);
    run(1'b0, "disjoint R2");

    // Stalled output on identical lists
    for (int i = 0; i < DEPTH; i++) begin la[i] = 5 * i; lb[i] = 5 * i; end
    load(0, DEPTH); load(1, DEPTH);
    run(1'b1, "stall R4");

    // Random lists
    for (int t = 0; t < 40; t++) begin
      int v;
      int n0 = $urandom % (DEPTH + 1);
      int n1 = $urandom % (DEPTH + 1);
      v = $urandom % 4;
      for (int i = 0; i < DEPTH; i++) begin la[i] = v; v += 1 + ($urandom % 3); end
      v = $urandom % 4;
      for (int i = 0; i < DEPTH; i++) begin lb[i] = v; v += 1 + ($urandom % 3); end
      load(0, n0); load(1, n1);
      run(t[0], "random R2 R3");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule